// File: doc/BRIEF.md
# Management Bus Master for PHY Register Access

This block is a register-programmed master for the two-wire management bus that reaches Ethernet PHY registers. Software sets a clock divider, a PHY address and a register address, and for writes a 16-bit data word. It then writes a command. The block serialises the management frame, drives the management clock and the data line with its output enable, and samples the data line during reads. Status bits report busy, link failure and whether scan data is valid yet.

In addition to single read and write transactions, a scan mode keeps reading register 1 of the selected PHY in the background, one frame after another. Each completed scan updates a link-fail flag from the link bit of that register. An optional mode drops the preamble so that a frame starts directly with its start bits.

Top module: `mgmt_bus_master`

## Requirements
- R1: After reset the mode word reads 0x0000000A (divider 10, preamble on), the command and status words read 0, MDC is low and the MDIO output enable is low.
- R2: Mode word bits 7:0 hold the clock divider. Bit 0 is forced to zero on write, so an odd value reads back one lower. MDC has a period of divider system clocks. Divider values 0 and 2 both give a period of 2.
- R3: Writing 1 to command bit 2 starts a write frame. The frame is 32 ones, start 01, opcode 01, a 5-bit PHY address, a 5-bit register address, turnaround 10 and then 16 data bits. Every field goes out MSB first.
- R4: A write transaction leaves the receive data word (offset 4) unchanged.
- R5: Writing 1 to command bit 1 starts a read frame with opcode 10. The MDIO output enable stays low from the first turnaround bit to the end of the frame, and whenever no frame is running. The 16 data bits are sampled on MDC rising edges, MSB first. They can be read at offset 4 once busy has fallen.
- R6: Status bit 1 (busy) reads 1 on the cycle after a read or write command is written. It returns to 0 when the frame has ended.
- R7: With mode bit 8 set, the preamble is left out and the frame starts with the start bits.
- R8: Setting command bit 0 enables scan. Status bit 2 (invalid) is then set, and busy stays 1 while scan is enabled. Repeated read frames go to register 1 of the programmed PHY address.
- R9: Every completed scan frame loads status bit 0 (link fail) with the inverse of bit 2 of the data read, and clears invalid.
- R10: Word offsets are 0 mode, 1 command, 2 address (PHY address in bits 4:0, register address in bits 12:8), 3 transmit data, 4 receive data and 5 status.
- R11: If command bits 2 and 1 are written as 1 together, a write frame is performed.
- R12: MDIO data and output enable change only on the system clock on which MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_in | input | 1 | Management data input |

## Verification
A wrong bit index or frame length in the shifter shows up within one frame. The PHY model then decodes a wrong opcode, address or data word, counts a preamble length other than 32 or 0, or returns a misaligned read value to the receive register. A stuck or early busy flag shows in the status word on the cycle after the command, or when the frame ends. A wrong divider shows as a wrong MDC period within two MDC cycles. Scan faults show after one or two complete frames as a wrong link-fail or invalid bit.

// File: rtl/mgb_pkg.sv
package mgb_pkg;
  localparam int PHY_W    = 5;
  localparam int DATA_W   = 16;
  localparam int REG_AW   = 3;
  localparam int BUS_W    = 32;
  localparam int RGAD_LSB = 8;

  localparam logic [REG_AW-1:0] RA_MODE = 3'd0;
  localparam logic [REG_AW-1:0] RA_CMD  = 3'd1;
  localparam logic [REG_AW-1:0] RA_ADDR = 3'd2;
  localparam logic [REG_AW-1:0] RA_TXD  = 3'd3;
  localparam logic [REG_AW-1:0] RA_RXD  = 3'd4;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd5;

  localparam int CMD_SCAN = 0;
  localparam int CMD_RD   = 1;
  localparam int CMD_WR   = 2;

  localparam int ST_LINK = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_INV  = 2;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/mgb_clkgen.sv
module mgb_clkgen #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half_cnt,
  output logic              mdc,
  output logic              rise_tick,
  output logic              fall_tick
);
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic              term;

  always_comb begin
    term  = (cnt_q >= (half_cnt - HALF_W'(1)));
    cnt_d = term ? '0 : cnt_q + HALF_W'(1);
    mdc_d = term ? ~mdc_q : mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term & ~mdc_q;
  assign fall_tick = term & mdc_q;
endmodule

// File: rtl/mgb_shifter.sv
module mgb_shifter
  import mgb_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  logic              nopre,
  input  logic [PHY_W-1:0]  phy,
  input  logic [PHY_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_out,
  output logic              mdio_oe
);
  localparam int HDR_LEN   = 2 + 2 + 2 * PHY_W + 2;
  localparam int FRAME_LEN = PRE_LEN + HDR_LEN + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_I   = IDX_W'(PRE_LEN + HDR_LEN - 2);
  localparam logic [IDX_W-1:0] DATA_I = IDX_W'(PRE_LEN + HDR_LEN);
  localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);

  sh_state_e             st_q, st_d;
  logic [IDX_W-1:0]      idx_q, idx_d, nidx;
  logic                  act_q, act_d;
  logic                  wr_q, wr_d;
  logic [FRAME_LEN-1:0]  frm_q, frm_d;
  logic                  out_q, out_d, oe_q, oe_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  fin;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    act_d = act_q;
    wr_d  = wr_q;
    frm_d = frm_q;
    out_d = out_q;
    oe_d  = oe_q;
    rx_d  = rx_q;
    fin   = 1'b0;
    nidx  = act_q ? idx_q + IDX_W'(1) : idx_q;
    case (st_q)
      SH_IDLE: begin
        if (start) begin
          st_d  = SH_RUN;
          wr_d  = start_wr;
          act_d = 1'b0;
          idx_d = nopre ? PRE_I : '0;
          frm_d = {{PRE_LEN{1'b1}}, 2'b01, (start_wr ? 2'b01 : 2'b10),
                   phy, regad, 2'b10,
                   (start_wr ? wdata : {DATA_W{1'b1}})};
        end
      end
      default: begin
        if (fall_tick) begin
          if (act_q && (idx_q == LAST_I)) begin
            fin   = 1'b1;
            st_d  = SH_IDLE;
            oe_d  = 1'b0;
            out_d = 1'b1;
          end else begin
            idx_d = nidx;
            act_d = 1'b1;
            out_d = frm_q[LAST_I - nidx];
            oe_d  = wr_q || (nidx < TA_I);
          end
        end
        if (rise_tick && act_q && !wr_q && (idx_q >= DATA_I))
          rx_d = {rx_q[DATA_W-2:0], mdio_in};
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      idx_q <= '0;
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      frm_q <= '0;
      out_q <= 1'b1;
      oe_q  <= 1'b0;
      rx_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      act_q <= act_d;
      wr_q  <= wr_d;
      frm_q <= frm_d;
      out_q <= out_d;
      oe_q  <= oe_d;
      rx_q  <= rx_d;
    end
  end

  assign busy     = (st_q == SH_RUN);
  assign done     = fin;
  assign rdata    = rx_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
endmodule

// File: rtl/mgb_regs.sv
module mgb_regs
  import mgb_pkg::*;
#(
  parameter int             DIV_W     = 8,
  parameter logic [7:0]     DIV_RESET = 8'd10,
  parameter int             SCAN_REG  = 1,
  parameter int             LINK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [DATA_W-1:0] sh_rdata,
  output logic [DIV_W-2:0]  half_cnt,
  output logic              nopre,
  output logic              start,
  output logic              start_wr,
  output logic [PHY_W-1:0]  phy,
  output logic [PHY_W-1:0]  regad,
  output logic [DATA_W-1:0] txd
);
  localparam int CMD_W = CMD_WR + 1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic              nopre_q, nopre_d;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [PHY_W-1:0]  phy_q, phy_d, rga_q, rga_d;
  logic [DATA_W-1:0] txd_q, txd_d, rxd_q, rxd_d;
  logic              link_q, link_d, inv_q, inv_d;
  logic              xwr_q, xwr_d, xscan_q, xscan_d;
  logic              wr_cmd, issue_wr, issue_rd, want_scan, scan_enable;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata;

  always_comb begin
    wr_cmd      = reg_wr && (reg_addr == RA_CMD);
    issue_wr    = wr_cmd && reg_wdata[CMD_WR];
    issue_rd    = wr_cmd && reg_wdata[CMD_RD] && !reg_wdata[CMD_WR];
    want_scan   = wr_cmd ? reg_wdata[CMD_SCAN] : cmd_q[CMD_SCAN];
    scan_enable = wr_cmd && reg_wdata[CMD_SCAN] && !cmd_q[CMD_SCAN];
    start       = !sh_busy && (issue_wr || issue_rd || want_scan);
    start_wr    = issue_wr;
  end

  always_comb begin
    div_d   = div_q;
    nopre_d = nopre_q;
    cmd_d   = cmd_q;
    phy_d   = phy_q;
    rga_d   = rga_q;
    txd_d   = txd_q;
    rxd_d   = rxd_q;
    link_d  = link_q;
    inv_d   = inv_q;
    xwr_d   = xwr_q;
    xscan_d = xscan_q;
    if (reg_wr) begin
      case (reg_addr)
        RA_MODE: begin
          div_d   = {reg_wdata[DIV_W-1:1], 1'b0};
          nopre_d = reg_wdata[DIV_W];
        end
        RA_CMD:  cmd_d = reg_wdata[CMD_W-1:0];
        RA_ADDR: begin
          phy_d = reg_wdata[PHY_W-1:0];
          rga_d = reg_wdata[RGAD_LSB +: PHY_W];
        end
        RA_TXD:  txd_d = reg_wdata[DATA_W-1:0];
        default: ;
      endcase
    end
    if (sh_done) begin
      if (!xwr_q)
        rxd_d = sh_rdata;
      if (xscan_q) begin
        link_d = ~sh_rdata[LINK_BIT];
        inv_d  = 1'b0;
      end
    end
    if (scan_enable)
      inv_d = 1'b1;
    if (start) begin
      xwr_d   = issue_wr;
      xscan_d = !(issue_wr || issue_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RESET);
      nopre_q <= 1'b0;
      cmd_q   <= '0;
      phy_q   <= '0;
      rga_q   <= '0;
      txd_q   <= '0;
      rxd_q   <= '0;
      link_q  <= 1'b0;
      inv_q   <= 1'b0;
      xwr_q   <= 1'b0;
      xscan_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      nopre_q <= nopre_d;
      cmd_q   <= cmd_d;
      phy_q   <= phy_d;
      rga_q   <= rga_d;
      txd_q   <= txd_d;
      rxd_q   <= rxd_d;
      link_q  <= link_d;
      inv_q   <= inv_d;
      xwr_q   <= xwr_d;
      xscan_q <= xscan_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_MODE: reg_rdata = BUS_W'({nopre_q, div_q});
      RA_CMD:  reg_rdata = BUS_W'(cmd_q);
      RA_ADDR: reg_rdata = BUS_W'({rga_q, {(RGAD_LSB-PHY_W){1'b0}}, phy_q});
      RA_TXD:  reg_rdata = BUS_W'(txd_q);
      RA_RXD:  reg_rdata = BUS_W'(rxd_q);
      RA_STAT: begin
        reg_rdata[ST_LINK] = link_q;
        reg_rdata[ST_BUSY] = sh_busy | cmd_q[CMD_SCAN];
        reg_rdata[ST_INV]  = inv_q;
      end
      default: ;
    endcase
  end

  assign half_cnt = (div_q[DIV_W-1:1] == '0) ? (DIV_W-1)'(1) : div_q[DIV_W-1:1];
  assign nopre    = nopre_q;
  assign phy      = phy_q;
  assign regad    = (issue_wr || issue_rd) ? rga_q : PHY_W'(SCAN_REG);
  assign txd      = txd_q;
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgb_pkg::*;
#(
  parameter int         DIV_W     = 8,
  parameter logic [7:0] DIV_RESET = 8'd10,
  parameter int         PRE_LEN   = 32,
  parameter int         SCAN_REG  = 1,
  parameter int         LINK_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  logic [DIV_W-2:0]  half_cnt;
  logic              nopre, sh_start, sh_start_wr, sh_busy, sh_done;
  logic              rise_tick, fall_tick;
  logic [PHY_W-1:0]  phy, regad;
  logic [DATA_W-1:0] txd, sh_rdata;

  mgb_regs #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .SCAN_REG(SCAN_REG), .LINK_BIT(LINK_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sh_busy(sh_busy),
    .sh_done(sh_done), .sh_rdata(sh_rdata), .half_cnt(half_cnt), .nopre(nopre),
    .start(sh_start), .start_wr(sh_start_wr), .phy(phy), .regad(regad), .txd(txd)
  );

  mgb_clkgen #(.HALF_W(DIV_W-1)) u_clk (
    .clk(clk), .rst_n(rst_n), .half_cnt(half_cnt), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgb_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .start_wr(sh_start_wr),
    .nopre(nopre), .phy(phy), .regad(regad), .wdata(txd),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_in(mdio_in),
    .busy(sh_busy), .done(sh_done), .rdata(sh_rdata),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mgb_checker.sv
module mgb_checker (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_out,
  input logic mdio_oe,
  input logic sh_busy,
  input logic sh_start,
  input logic sh_done
);
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> !mdio_oe); // R5

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_out) |-> $fell(mdc)); // R12

  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc)); // R12

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |=> sh_busy); // R6

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |=> !sh_busy); // R6
endmodule

bind mgmt_bus_master mgb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
  .sh_busy(sh_busy), .sh_start(sh_start), .sh_done(sh_done)
);

// File: tb/mgmt_bus_master_test.sv
module mgmt_bus_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;

  mgmt_bus_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model
  logic [15:0] phy_regs [32];
  int          pos = 0;
  int          ones = 0;
  logic [31:0] fr = '0;
  logic        cur_rd = 1'b0;
  logic [15:0] rd_val = '0;
  logic        seen_oe = 1'b0;
  int          frames = 0;
  logic [1:0]  last_op = '0;
  logic [1:0]  last_ta = '0;
  logic [4:0]  last_phy = '0;
  logic [4:0]  last_reg = '0;
  logic [15:0] last_data = '0;
  int          last_pre = 0;
  logic        last_rd_oe = 1'b0;

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'hA500 + 16'(i);
  end

  always @(posedge mdc) begin
    logic line;
    line = mdio_oe ? mdio_out : 1'b1;
    if (pos == 0) begin
      if (mdio_oe && line) ones++;
      else if (mdio_oe && !line) begin
        pos = 1; fr = '0; seen_oe = 1'b0;
      end
    end else begin
      fr = {fr[30:0], line};
      pos++;
      if (pos == 4) cur_rd = (fr[1:0] == 2'b10);
      if (pos == 14) rd_val = phy_regs[fr[4:0]];
      if (pos >= 15 && cur_rd && mdio_oe) seen_oe = 1'b1;
      if (pos == 32) begin
        last_op = fr[29:28]; last_phy = fr[27:23]; last_reg = fr[22:18];
        last_ta = fr[17:16]; last_data = fr[15:0];
        last_pre = ones; last_rd_oe = seen_oe;
        if (fr[29:28] == 2'b01) phy_regs[fr[22:18]] = fr[15:0];
        ones = 0; pos = 0; frames++;
      end
    end
  end

  always @(negedge mdc) begin
    if (pos >= 16 && pos <= 31 && cur_rd) mdio_in = rd_val[31-pos];
    else mdio_in = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n;
    n = 0;
    do begin
      reg_read(3'd5, s);
      n++;
    end while (s[1] && n < 20000);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    int target;
    int guard;
    target = frames + n;
    guard = 0;
    while (frames < target && guard < 50000) begin
      @(posedge clk);
      guard++;
    end
    repeat (20) @(posedge clk);
  endtask

  task automatic mdc_period(output int per);
    time t0;
    @(posedge mdc); @(posedge mdc);
    t0 = $time;
    @(posedge mdc);
    per = int'(($time - t0) / CLK_PERIOD);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(3'd0, d); chk("R1 mode reset", d, 32'h0000000A);
    reg_read(3'd1, d); chk("R1 cmd reset", d, 32'h0);
    reg_read(3'd5, d); chk("R1 status reset", d, 32'h0);
    chk("R1 oe reset", {31'd0, mdio_oe}, 32'd0);
  endtask

  task automatic t_divider();
    logic [31:0] d;
    int per;
    reg_write(3'd0, 32'd7);
    reg_read(3'd0, d); chk("R2 odd divider forced even", d, 32'd6);
    mdc_period(per); chk("R2 period div 6", 32'(per), 32'd6);
    reg_write(3'd0, 32'd0);
    mdc_period(per); chk("R2 period div 0", 32'(per), 32'd2);
    reg_write(3'd0, 32'd10);
    mdc_period(per); chk("R2 period div 10", 32'(per), 32'd10);
  endtask

  task automatic t_read();
    logic [31:0] d;
    reg_write(3'd2, 32'h0000_0403);
    reg_read(3'd2, d); chk("R10 address word layout", d, 32'h0000_0403);
    reg_write(3'd1, 32'd2);
    reg_read(3'd5, d); chk("R6 busy after read issue", {31'd0, d[1]}, 32'd1);
    wait_idle();
    reg_read(3'd5, d); chk("R6 busy cleared after read", d, 32'd0);
    reg_write(3'd1, 32'd0);
    reg_read(3'd4, d); chk("R5 read data", d, 32'h0000A504);
    chk("R5 read opcode", 32'(last_op), 32'd2);
    chk("R5 read phy/reg", {22'd0, last_phy, last_reg}, {22'd0, 5'd3, 5'd4});
    chk("R5 oe released in turnaround/data", 32'(last_rd_oe), 32'd0);
    chk("R5 oe low when idle", 32'(mdio_oe), 32'd0);
  endtask

  task automatic t_write();
    logic [31:0] d;
    reg_write(3'd2, 32'h0000_0905);
    reg_write(3'd3, 32'h0000_BEEF);
    reg_write(3'd1, 32'd4);
    reg_read(3'd5, d); chk("R6 busy after write issue", {31'd0, d[1]}, 32'd1);
    wait_idle();
    reg_write(3'd1, 32'd0);
    chk("R3 write opcode", 32'(last_op), 32'd1);
    chk("R3 preamble length", 32'(last_pre), 32'd32);
    chk("R3 turnaround", 32'(last_ta), 32'd2);
    chk("R3 phy/reg", {22'd0, last_phy, last_reg}, {22'd0, 5'd5, 5'd9});
    chk("R3 write data", 32'(last_data), 32'h0000BEEF);
    reg_read(3'd4, d); chk("R4 rx data unchanged by write", d, 32'h0000A504);
  endtask

  task automatic t_nopre();
    logic [31:0] d;
    reg_write(3'd0, 32'h0000010A);
    reg_write(3'd2, 32'h0000_0603);
    reg_write(3'd1, 32'd2);
    wait_idle();
    reg_write(3'd1, 32'd0);
    chk("R7 no preamble", 32'(last_pre), 32'd0);
    reg_read(3'd4, d); chk("R7 read data without preamble", d, 32'h0000A506);
    reg_write(3'd0, 32'h0000000A);
  endtask

  task automatic t_priority();
    reg_write(3'd2, 32'h0000_0307);
    reg_write(3'd3, 32'h0000_1234);
    reg_write(3'd1, 32'd6);
    wait_idle();
    reg_write(3'd1, 32'd0);
    chk("R11 write wins opcode", 32'(last_op), 32'd1);
    chk("R11 phy register written", 32'(phy_regs[3]), 32'h00001234);
  endtask

  task automatic t_scan();
    logic [31:0] d;
    phy_regs[1] = 16'h7809;
    reg_write(3'd2, 32'h0000_0002);
    reg_write(3'd1, 32'd1);
    reg_read(3'd5, d); chk("R8 invalid and busy on scan start", d, 32'd6);
    wait_frames(1);
    reg_read(3'd5, d); chk("R9 link fail after first scan", d, 32'd3);
    chk("R8 scan targets register 1", {22'd0, last_phy, last_reg}, {22'd0, 5'd2, 5'd1});
    chk("R8 scan uses read opcode", 32'(last_op), 32'd2);
    phy_regs[1] = 16'h780D;
    wait_frames(2);
    reg_read(3'd5, d); chk("R9 link restored", d, 32'd2);
    reg_write(3'd1, 32'd0);
    wait_idle();
    reg_read(3'd5, d); chk("R8 scan stopped", d, 32'd0);
    reg_read(3'd4, d); chk("R9 scan data in rx word", d, 32'h0000780D);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_divider();
    t_read();
    t_write();
    t_nopre();
    t_priority();
    t_scan();
    finish_run();
  end
endmodule